// File: doc/BRIEF.md
# Byte-Unpacking Transmit Buffer

This block is the outbound data store of a card host controller. The register bus deposits 1, 2 or 4 bytes in one access. The block splits each access into single bytes and stores them in a 32-entry circular byte buffer. The highest-order byte of the access goes in first. A byte-wide read port hands the oldest byte to the card data serialiser, one byte per cycle.

The block raises a transmit-request interrupt when the buffer runs dry, and every bus write drops it. Bytes that arrive when there is no room are thrown away silently, and the bus access still completes. A partial-buffer command empties the buffer at once. The fill level, full and empty are visible at all times.

Top module: `txb_top`

## Requirements
- R1: After reset the level is 0, empty_o is 1, full_o is 0 and tx_req_o is 1.
- R2: wr_size_i selects the byte count of a write: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. The level rises by that count when there is room.
- R3: Bytes of one write are queued from the most significant byte down. For an N-byte write, wr_data_i[8*N-1:8*N-8] is queued first and wr_data_i[7:0] last.
- R4: A write stores only as many bytes as there are free entries, counted from the level before that cycle. The remaining bytes are discarded, and the stored contents and the level never exceed 32.
- R5: With rd_en_i high and the buffer not empty, exactly one byte is removed in that cycle. rd_en_i on an empty buffer changes nothing.
- R6: Whenever empty_o is 0, rd_data_o shows the oldest byte still stored.
- R7: A write and a read in the same cycle both take effect. The new level is the old level plus the bytes stored minus one.
- R8: flip_i discards all contents and sets the level to 0. A read in the same cycle is ignored. A write in the same cycle is stored into the emptied buffer.
- R9: Every write (wr_en_i high) clears tx_req_o in the next cycle, even if no byte of it is stored.
- R10: tx_req_o is set when the level goes from nonzero to zero in a cycle without a write. Otherwise it holds.
- R11: full_o is 1 exactly when the level is 32, and empty_o is 1 exactly when the level is 0.
- R12: Storage is circular modulo 32, so long mixed traffic keeps order across any number of pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write to the transmit data register |
| wr_size_i | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| wr_data_i | input | 32 | Write data, used from the most significant valid byte down |
| flip_i | input | 1 | Partial-buffer command: empty the buffer |
| rd_en_i | input | 1 | Serialiser takes one byte |
| rd_data_o | output | 8 | Oldest stored byte |
| level_o | output | 6 | Number of stored bytes, 0 to 32 |
| full_o | output | 1 | Level equals 32 |
| empty_o | output | 1 | Level equals 0 |
| tx_req_o | output | 1 | Transmit-request interrupt |

## Verification
Each access size is first written into an empty buffer with distinct byte values, then drained. Any lane swap or wrong byte count shows up in both the read order and the level. Near-full fills of 30 and 31 bytes followed by 4-byte writes separate truncation from complete discard. Simultaneous read and write at partial and full levels show whether room is counted before or after the read. Flip is tried alone, with a write and with a read. A long pseudo-random mix of all inputs drives the pointers through many wraps, while a queue model checks every output on every cycle.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } wr_size_e;

  function automatic int size_bytes(input logic [1:0] code);
    case (wr_size_e'(code))
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/txb_unpack.sv
module txb_unpack #(
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic [1:0]          size_i,
  input  logic [LANES*DW-1:0] data_i,
  output logic [CW-1:0]       nbytes_o,
  output logic [DW-1:0]       lane_o [LANES]
);
  int n_bytes;

  always_comb begin
    n_bytes = txb_pkg::size_bytes(size_i);
    if (n_bytes > LANES) n_bytes = LANES;
    nbytes_o = CW'(n_bytes);
  end

  // lane 0 takes the top valid byte, so it is queued first
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      lane_o[i] = '0;
      for (int j = 0; j < LANES; j++) begin
        if ((i < n_bytes) && (j == n_bytes - 1 - i)) lane_o[i] = data_i[j*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/txb_ptr_ctrl.sv
module txb_ptr_ctrl #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CW-1:0]    nbytes_i,
  input  logic             flip_i,
  input  logic             rd_en_i,
  output logic [LANES-1:0] lane_we_o,
  output logic [AW-1:0]    lane_idx_o [LANES],
  output logic [AW-1:0]    head_o,
  output logic [AW:0]      len_o,
  output logic             req_o
);
  logic [AW:0]   start_q, start_d, len_q, len_d, base_len, room;
  logic [CW-1:0] stored;
  logic          pop, req_q, req_d;

  always_comb begin
    pop      = rd_en_i && !flip_i && (len_q != '0);
    base_len = flip_i ? '0 : len_q;
    room     = (AW+1)'(DEPTH) - base_len;
    stored   = '0;
    for (int i = 0; i < LANES; i++) begin
      // room counted from the level before this cycle's read
      lane_we_o[i]  = wr_en_i && (CW'(i) < nbytes_i) && ((AW+1)'(i) < room);
      lane_idx_o[i] = start_q[AW-1:0] + base_len[AW-1:0] + AW'(i);
      stored        = stored + CW'(lane_we_o[i]);
    end
    len_d   = base_len + (AW+1)'(stored) - (AW+1)'(pop);
    start_d = flip_i ? (start_q ^ {1'b1, {AW{1'b0}}}) : (start_q + (AW+1)'(pop));
    if (wr_en_i)                          req_d = 1'b0;
    else if (len_q != '0 && len_d == '0)  req_d = 1'b1;
    else                                  req_d = req_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      len_q   <= '0;
      req_q   <= 1'b1;
    end else begin
      start_q <= start_d;
      len_q   <= len_d;
      req_q   <= req_d;
    end
  end

  assign head_o = start_q[AW-1:0];
  assign len_o  = len_q;
  assign req_o  = req_q;
endmodule

// File: rtl/txb_store.sv
module txb_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] lane_we_i,
  input  logic [AW-1:0]    lane_idx_i [LANES],
  input  logic [DW-1:0]    lane_data_i [LANES],
  input  logic [AW-1:0]    rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // lane indices are distinct within a cycle, so at most one lane hits an entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we_i[i] && (lane_idx_i[i] == AW'(e))) mem_q[e] <= lane_data_i[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/txb_top.sv
module txb_top #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_size_i,
  input  logic [LANES*DW-1:0] wr_data_i,
  input  logic                flip_i,
  input  logic                rd_en_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [AW:0]         level_o,
  output logic                full_o,
  output logic                empty_o,
  output logic                tx_req_o
);
  logic [CW-1:0]    nbytes;
  logic [DW-1:0]    lane_data [LANES];
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    lane_idx [LANES];
  logic [AW-1:0]    head;
  logic [AW:0]      len;

  txb_unpack #(.DW(DW), .LANES(LANES), .CW(CW)) u_unpack (
    .size_i  (wr_size_i),
    .data_i  (wr_data_i),
    .nbytes_o(nbytes),
    .lane_o  (lane_data)
  );

  txb_ptr_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .AW(AW), .CW(CW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .nbytes_i  (nbytes),
    .flip_i    (flip_i),
    .rd_en_i   (rd_en_i),
    .lane_we_o (lane_we),
    .lane_idx_o(lane_idx),
    .head_o    (head),
    .len_o     (len),
    .req_o     (tx_req_o)
  );

  txb_store #(.DEPTH(DEPTH), .DW(DW), .LANES(LANES), .AW(AW)) u_store (
    .clk_i      (clk_i),
    .lane_we_i  (lane_we),
    .lane_idx_i (lane_idx),
    .lane_data_i(lane_data),
    .rd_idx_i   (head),
    .rd_data_o  (rd_data_o)
  );

  assign level_o = len;
  assign full_o  = (len == (AW+1)'(DEPTH));
  assign empty_o = (len == '0);
endmodule

// File: rtl/txb_chk.sv
module txb_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_size_i,
  input logic        flip_i,
  input logic        rd_en_i,
  input logic [AW:0] level_o,
  input logic        full_o,
  input logic        empty_o,
  input logic        tx_req_o
);
  AST_BYTE_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_size_i == 2'd0 && !full_o && !rd_en_i && !flip_i |=> level_o == $past(level_o) + 1); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_en_i && !flip_i |=> full_o && level_o == (AW+1)'(DEPTH)); // R4
  AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !empty_o && !wr_en_i && !flip_i |=> level_o == $past(level_o) - 1); // R5
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && empty_o && !wr_en_i && !flip_i |=> empty_o); // R5
  AST_FLIP_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_i && !wr_en_i |=> empty_o); // R8
  AST_WR_CLEARS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tx_req_o); // R9
  AST_REQ_ON_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && level_o == 1 && !wr_en_i && !flip_i |=> tx_req_o); // R10
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= (AW+1)'(DEPTH)); // R11
endmodule

bind txb_top txb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_size_i(wr_size_i),
  .flip_i   (flip_i),
  .rd_en_i  (rd_en_i),
  .level_o  (level_o),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .tx_req_o (tx_req_o)
);

// File: tb/tb_txb_top.sv
`timescale 1ns/1ps
module tb_txb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd0;
  logic [31:0] wr_data = '0;
  logic        flip = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [5:0]  level;
  logic        full, empty, tx_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  byte unsigned q[$];
  bit req_m = 1'b1;

  always #2.5 clk = ~clk;

  txb_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_size_i(wr_size),
    .wr_data_i(wr_data), .flip_i(flip), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .level_o(level), .full_o(full), .empty_o(empty), .tx_req_o(tx_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "level", int'(level), q.size());
    chk(tag, "full", int'(full), int'(q.size() == 32));
    chk(tag, "empty", int'(empty), int'(q.size() == 0));
    chk(tag, "tx_req", int'(tx_req), int'(req_m));
    if (q.size() > 0) chk(tag, "rd_data", int'(rd_data), int'(q[0]));
  endtask

  task automatic model_step();
    int n, old, base;
    bit pop;
    n    = (wr_size == 2'd0) ? 1 : (wr_size == 2'd1) ? 2 : 4;
    old  = q.size();
    if (flip) q.delete();
    base = q.size();
    pop  = rd_en && !flip && old > 0;
    if (wr_en)
      for (int k = 0; k < n; k++)
        if (base + k < 32) q.push_back(wr_data[8*(n-1-k) +: 8]);
    if (pop) void'(q.pop_front());
    if (wr_en) req_m = 1'b0;
    else if (old != 0 && q.size() == 0) req_m = 1'b1;
  endtask

  task automatic cyc(bit we, logic [1:0] sz, logic [31:0] d, bit fl, bit rd, string tag);
    wr_en = we; wr_size = sz; wr_data = d; flip = fl; rd_en = rd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drain(string tag);
    while (q.size() > 0) cyc(0, 2'd0, '0, 0, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    // R9: a write clears the request raised at reset
    cyc(1, 2'd0, 32'hFFFF_FF5A, 0, 0, "R9");
    cyc(1, 2'd1, 32'hFFFF_A1B2, 0, 0, "R2");
    cyc(1, 2'd2, 32'hC3D4_E5F6, 0, 0, "R2");
    cyc(1, 2'd3, 32'h1122_3344, 0, 0, "R2");
    // R3: drain checks MSB-first byte order; R10: request back on empty
    drain("R3");
    compare("R10");
    cyc(0, 2'd0, '0, 0, 1, "R5");

    // R4: fill to 30, then a 4-byte write keeps only 2
    for (int i = 0; i < 7; i++) cyc(1, 2'd2, 32'h1000_0000 + i * 32'h0101_0101, 0, 0, "R4");
    cyc(1, 2'd1, 32'h0000_7E7F, 0, 0, "R4");
    cyc(1, 2'd2, 32'hAABB_CCDD, 0, 0, "R4");
    compare("R11");
    cyc(1, 2'd2, 32'h9999_9999, 0, 0, "R4");
    cyc(0, 2'd0, '0, 0, 0, "R4");
    // R7: read and write at full: no room, level drops to 31
    cyc(1, 2'd2, 32'h5555_6666, 0, 1, "R7");
    cyc(1, 2'd0, 32'h0000_0077, 0, 1, "R7");
    cyc(1, 2'd1, 32'h0000_8899, 0, 1, "R7");
    drain("R6");

    cyc(1, 2'd2, 32'h0102_0304, 0, 1, "R7");
    cyc(1, 2'd2, 32'h0506_0708, 0, 1, "R7");
    // R8: flip alone, flip with read, flip with write
    cyc(0, 2'd0, '0, 1, 0, "R8");
    cyc(1, 2'd1, 32'h0000_ABCD, 0, 0, "R8");
    cyc(0, 2'd0, '0, 1, 1, "R8");
    cyc(1, 2'd2, 32'hDEAD_BEEF, 0, 0, "R8");
    cyc(1, 2'd1, 32'h0000_CAFE, 1, 1, "R8");
    drain("R8");

    // R12: long mixed traffic across many wraps
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom_range(0, 99) < 45), 2'($urandom_range(0, 3)), $urandom(),
          ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 60), "R12");
    end
    drain("R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule